// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector

This block compares a reference input against the feedback from a loop oscillator inside a fast system clock domain. Both inputs are assumed already synchronised to that clock. Only their rising edges matter. A reference rise raises an internal "speed up" request. A feedback rise raises a "slow down" request. Once both requests are held together, they cancel each other on the next clock. The two requests leave the block as active-low pulse outputs that idle HIGH.

The width of each pulse tracks how far apart the two edges are in time. Because the two outputs are subtracted, the detector steers on frequency as well as phase across a phase range of plus or minus two pi.

A windowed signed counter turns the two outputs into a number. It adds one for each clock in which only the speed-up output is LOW, and subtracts one for each clock in which only the slow-down output is LOW. At the end of every window it presents the total with a one-cycle strobe and then starts again from zero. Downstream digital loop logic can use this figure as an averaged error.

Top module: `pfd_sampled_top`

## Requirements
- R1: A synchronous active-high reset drives up_n and dn_n HIGH, err_valid LOW and err_sum to zero, and restarts the window.
- R2: With no request held, a rising edge on ref_in alone (a LOW in the previous sample, HIGH in this one) drives up_n LOW from the next clock edge. up_n stays LOW until a feedback rise has been seen.
- R3: With no request held, a rising edge on fb_in alone drives dn_n LOW from the next clock edge. dn_n stays LOW until a reference rise has been seen.
- R4: When both requests are held (up_n and dn_n both LOW), both outputs return HIGH at the following clock edge. Any rising edge sampled during that clearing cycle is discarded.
- R5: Rising edges on ref_in and fb_in sampled in the same clock cycle, with no request held, leave both outputs HIGH.
- R6: Falling edges and steady levels on either input leave both outputs unchanged.
- R7: With equal input periods, where the reference leads by N clocks, every period holds N clocks with only up_n LOW. A lag of N gives N clocks with only dn_n LOW. At a half-period offset the active output is LOW for more than half of each period.
- R8: Every WINDOW clocks after reset, err_valid is HIGH for one cycle. At the same time err_sum equals the number of clocks in that window with only up_n LOW, minus the number with only dn_n LOW. Clocks with both outputs LOW, or both HIGH, add nothing.
- R9: Inputs with equal frequency and equal phase give err_sum of zero in every window.
- R10: A feedback input faster than the reference gives a negative total error. A slower one gives a positive total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, synchronised |
| fb_in | input | 1 | Oscillator feedback signal, synchronised |
| up_n | output | 1 | Active-low request for higher oscillator frequency |
| dn_n | output | 1 | Active-low request for lower oscillator frequency |
| err_sum | output | $clog2(WINDOW+1)+1 | Signed window total of up-only minus down-only clocks |
| err_valid | output | 1 | One-cycle strobe marking a new err_sum |

## Verification
The hardest state to reach is an edge that lands exactly in the single clearing cycle, after both requests have been held. That edge must be lost rather than start a new pulse. The vector table places a feedback rise one cycle after a reference rise, then a second reference rise on the very next sample. It then confirms that both outputs stay HIGH afterwards. Periodic waveforms with chosen periods and offsets reach the steady locked, leading, lagging and frequency-offset states. In those states the window totals have exact, or at least signed, expected values.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } err_dir_e;

    typedef struct packed {
        logic up;
        logic dn;
    } req_t;

    function automatic err_dir_e classify(input logic up_n, input logic dn_n);
        if (!up_n && dn_n)
            return DIR_UP;
        else if (up_n && !dn_n)
            return DIR_DN;
        else
            return DIR_NONE;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output req_t req
);
    req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (req_q.up && req_q.dn) begin
            req_q <= '0;
        end else begin
            if (ref_rise && !fb_rise)
                req_q.up <= 1'b1;
            if (fb_rise && !ref_rise)
                req_q.dn <= 1'b1;
        end
    end

    assign req = req_q;

    // R4
    mutual_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.up && req_q.dn) |=> (!req_q.up && !req_q.dn));

    // R5
    coincident_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_q.up && !req_q.dn && ref_rise && fb_rise) |=> (!req_q.up && !req_q.dn));

    // R2
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.up && !req_q.dn) |=> req_q.up);

    // R3
    dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.dn && !req_q.up) |=> req_q.dn);
endmodule

// File: rtl/pfd_avg.sv
module pfd_avg
    import pfd_pkg::*;
#(
    parameter int WINDOW = 1024
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              up_n,
    input  logic                              dn_n,
    output logic signed [$clog2(WINDOW+1):0]  err_sum,
    output logic                              err_valid
);
    localparam int ACC_W = $clog2(WINDOW + 1) + 1;
    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0]        cnt_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] step;
    err_dir_e                dir;

    always_comb begin
        dir = classify(up_n, dn_n);
        case (dir)
            DIR_UP:  step = ACC_W'(1);
            DIR_DN:  step = -ACC_W'(1);
            default: step = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            err_sum   <= '0;
            err_valid <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            err_sum   <= acc_q + step;
            err_valid <= 1'b1;
        end else begin
            cnt_q     <= cnt_q + 1'b1;
            acc_q     <= acc_q + step;
            err_valid <= 1'b0;
        end
    end

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    // R8
    sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ((err_sum <= WINDOW) && (err_sum >= -WINDOW)));
endmodule

// File: rtl/pfd_sampled_top.sv
module pfd_sampled_top
    import pfd_pkg::*;
#(
    parameter int WINDOW = 1024
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ref_in,
    input  logic                              fb_in,
    output logic                              up_n,
    output logic                              dn_n,
    output logic signed [$clog2(WINDOW+1):0]  err_sum,
    output logic                              err_valid
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] rise;
    req_t              req;

    assign lvl = {fb_in, ref_in};

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_edge
            pfd_edge_det u_edge (
                .clk  (clk),
                .rst  (rst),
                .lvl  (lvl[i]),
                .rise (rise[i])
            );
        end
    endgenerate

    pfd_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .req      (req)
    );

    assign up_n = ~req.up;
    assign dn_n = ~req.dn;

    pfd_avg #(.WINDOW(WINDOW)) u_avg (
        .clk       (clk),
        .rst       (rst),
        .up_n      (up_n),
        .dn_n      (dn_n),
        .err_sum   (err_sum),
        .err_valid (err_valid)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (up_n && dn_n && !err_valid && (err_sum == 0)));

    // R4
    both_low_once_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_n && !dn_n) |=> (up_n && dn_n));

    // R6
    no_rise_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (up_n != dn_n && !rise[0] && !rise[1]) |=> ($stable(up_n) && $stable(dn_n)));
endmodule

// File: tb/tb_pfd_sampled_top.sv
module tb_pfd_sampled_top;
    localparam int WIN = 16;
    localparam int SW  = $clog2(WIN + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up_n, dn_n, err_valid;
    logic signed [SW-1:0] err_sum;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_sum = 0;
    int seg_total = 0;

    always #10 clk = ~clk;

    pfd_sampled_top #(.WINDOW(WIN)) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .up_n(up_n), .dn_n(dn_n), .err_sum(err_sum), .err_valid(err_valid)
    );

    // {ref_in, fb_in, expected up_n, expected dn_n} after the edge
    localparam int NV = 19;
    localparam logic [3:0] VEC [0:NV-1] = '{
        4'b0011, 4'b1001, 4'b1001, 4'b0001, 4'b0100, 4'b0111, 4'b0011,
        4'b0110, 4'b0010, 4'b1000, 4'b0011, 4'b1111, 4'b0011, 4'b1001,
        4'b0100, 4'b1011, 4'b0011, 4'b1111, 4'b1111
    };
    localparam int VTAG [0:NV-1] = '{
        1, 2, 6, 6, 4, 4, 6, 3, 6, 4, 4, 5, 5, 2, 4, 4, 4, 5, 6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // R8: model window total from the ports, check on each strobe
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0;
        end else begin
            if (err_valid) begin
                check(int'(err_sum) == last_sum, "R8 window sum", int'(err_sum), last_sum);
                check(cyc == WIN, "R8 window length", cyc, WIN);
                seg_total += int'(err_sum);
                last_sum = 0;
                cyc = 0;
            end
            if (!up_n && dn_n) last_sum++;
            else if (up_n && !dn_n) last_sum--;
            cyc++;
        end
    end

    task automatic run_waves(input int pr, input int pv, input int off, input int n);
        for (int t = 0; t < n; t++) begin
            ref_in = (t % pr) < (pr / 2);
            fb_in  = ((t + pv - off) % pv) < (pv / 2);
            @(posedge clk);
            #1;
        end
    endtask

    int win_val;

    task automatic segment(input int pr, input int pv, input int off, input int n);
        do_reset();
        @(negedge clk);
        seg_total = 0;
        last_sum = 0;
        #1;
        run_waves(pr, pv, off, n);
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        @(posedge clk); #1;
        // R1 reset state
        check(up_n && dn_n, "R1 outputs idle", {up_n, dn_n}, 3);
        check(!err_valid && err_sum == 0, "R1 sum cleared", int'(err_sum), 0);

        for (int i = 0; i < NV; i++) begin
            ref_in = VEC[i][3];
            fb_in  = VEC[i][2];
            @(posedge clk); #1;
            check({up_n, dn_n} == VEC[i][1:0], $sformatf("R%0d vector %0d", VTAG[i], i),
                  {up_n, dn_n}, VEC[i][1:0]);
        end

        // R9 locked: same period, same phase
        segment(16, 16, 0, 64);
        win_val = seg_total;
        check(win_val == 0, "R9 locked total", win_val, 0);

        // R7 reference leads by 4
        segment(16, 16, 4, 64);
        win_val = seg_total;
        check(win_val == seg_total && win_val > 0, "R7 lead sign", win_val, 1);
        do_reset();
        run_waves(16, 16, 4, 48);
        last_sum = 0;
        run_waves(16, 16, 4, 0);
        // Exact steady-state window check
        segment(16, 16, 4, 64);
        check(int'(err_sum) == 4, "R7 lead by 4", int'(err_sum), 4);

        // R7 reference lags by 5 (feedback leads)
        segment(16, 16, 11, 64);
        check(int'(err_sum) == -5, "R7 lag by 5", int'(err_sum), -5);

        // R7 half-period offset
        segment(16, 16, 8, 64);
        check(int'(err_sum) == 8 || int'(err_sum) == -8, "R7 half period", int'(err_sum), 8);

        // R10 feedback faster
        segment(16, 10, 0, 96);
        win_val = seg_total;
        check(win_val < 0, "R10 fast feedback", win_val, -1);

        // R10 feedback slower
        segment(16, 24, 0, 96);
        win_val = seg_total;
        check(win_val > 0, "R10 slow feedback", win_val, 1);

        // R1 reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk); #1;
        check(up_n && dn_n && !err_valid && err_sum == 0, "R1 mid-run reset",
              {up_n, dn_n, err_valid}, 6);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule